// File: doc/BRIEF.md
# Switch configuration request router

This block sits at the top of a multi-port switch and decides where each configuration request goes. A request carries a forward flag, a read/write flag, a bus number, a device/function number, a dword register index and write data. A request with the forward flag clear is aimed at the switch's own upstream bridge. It is always claimed and is served by the upstream register file.

A forwarded request is claimed only when the upstream bridge's bus window has been programmed and the target bus lies inside that window. A request for the window's first (secondary) bus reaches the internal bus. There the device/function number picks one downstream port register file. A request for any other bus inside the window is handed to the lowest-numbered downstream port whose own programmed window contains that bus. Every other request is left unclaimed.

The block holds the bus number registers for the upstream port and for each of the `N_DN` downstream ports. It also returns the read-only identity, header type and slot values of each port. The answer comes out registered, one clock after the request.

Top module: `cfg_route_switch`

## Requirements
- R1: A synchronous active-low reset clears every port's bus number register to zero, so every window becomes unprogrammed, and drives `rsp_valid` low.
- R2: A request with `req_fwd`=0 is always claimed with kind 1 (own). Its read data comes from the upstream register file, and a write goes only to that file.
- R3: Register index 0 of every port reads the device ID in bits 31:16 and the vendor ID in bits 15:0. The upstream port and the downstream ports use different device IDs.
- R4: Register index 3 reads the header byte in bits 23:16, with type 0x01 in bits 22:16. Bit 23 (multi-function) is set on a downstream port only when `N_DN` > 1, and it is never set on the upstream port.
- R5: Register index 6 is the bus number register, and all four of its bytes are written and read back. Byte 1 is the secondary bus and byte 2 is the subordinate bus, and these two bytes define the window. Byte 0 is the primary bus, and byte 3 is stored with no effect. A write to any other register index changes nothing.
- R6: A window counts as unprogrammed while its secondary and subordinate bytes are both zero. A forwarded request is left unclaimed while the upstream window is unprogrammed.
- R7: A forwarded request whose bus is below the upstream secondary bus or above the upstream subordinate bus is left unclaimed.
- R8: A forwarded request whose bus equals the upstream secondary bus is claimed with kind 2 (internal). `rsp_port` then equals `req_devfn`, and the request reads or writes that downstream port's register file. If `req_devfn` >= `N_DN`, the request is left unclaimed.
- R9: A forwarded request for any other bus inside the upstream window is claimed with kind 3 (forward). `rsp_port` is the lowest-index downstream port whose programmed window contains the bus, and unprogrammed ports are skipped. If no port matches, the request is left unclaimed.
- R10: Register index 16 reads a slot number in bits 7:0. With `HOTPLUG`=1 this is i+1 on downstream port i, and otherwise it is zero. The upstream port always reads zero here.
- R11: The response appears one cycle after a request, with `rsp_valid` high. No request gives no response. An unclaimed request returns kind 0, port 0 and read data 0xFFFFFFFF. A forwarded request returns read data 0. A register-file target returns the register value from before the request's own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_fwd | input | 1 | 1: forwarded (type-1) request; 0: access to the upstream bridge itself |
| req_write | input | 1 | 1: write, 0: read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device/function number |
| req_reg | input | 6 | Dword register index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_claimed | output | 1 | The request was claimed |
| rsp_kind | output | 2 | 0 none, 1 own, 2 internal port file, 3 forwarded |
| rsp_port | output | PORT_W | Selected downstream port for kinds 2 and 3, otherwise 0 |
| rsp_rdata | output | 32 | Read data |

## Verification
Every result is registered once: inputs are sampled on a rising edge, and the result is on the outputs from that edge until the next request. The bench drives a request on a falling edge and compares the outputs on the following falling edge, which is half a cycle after the capturing edge. Because of this, a check never races the edge. Write effects are checked through a later read or routing decision, never in the same response, because a response reports the register contents from before its own write. Bus window changes take effect for the next request.

// File: rtl/cfg_route_pkg.sv
// Shared types and constants for the configuration router.
// Assumes dword register indices (byte offset divided by four).
package cfg_route_pkg;

    typedef enum logic [1:0] {
        KIND_NONE     = 2'd0,
        KIND_OWN      = 2'd1,
        KIND_INTERNAL = 2'd2,
        KIND_FORWARD  = 2'd3
    } route_kind_e;

    localparam logic [5:0] REG_IDENT = 6'd0;
    localparam logic [5:0] REG_HDR   = 6'd3;
    localparam logic [5:0] REG_BUSNR = 6'd6;
    localparam logic [5:0] REG_SLOT  = 6'd16;

    localparam logic [6:0] HDR_TYPE_BRIDGE = 7'h01;
    localparam logic [31:0] RDATA_UNCLAIMED = 32'hFFFF_FFFF;

    // A window is present once either bound has been written non-zero.
    function automatic logic window_set(input logic [7:0] sec, input logic [7:0] sub);
        return (sec != 8'd0) || (sub != 8'd0);
    endfunction

endpackage

// File: rtl/cfg_port_regs.sv
// One bridge port's configuration registers: fixed identity, header and
// slot values plus the writable bus number register.
// Assumes one access per cycle; the write lands on the clock edge.
module cfg_port_regs
    import cfg_route_pkg::*;
#(
    parameter logic [15:0] VEN_ID   = 16'h1A2B,
    parameter logic [15:0] DEV_ID   = 16'h0C01,
    parameter bit          MULTI_FN = 1'b0,
    parameter logic [7:0]  SLOT_NUM = 8'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  reg_idx,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [7:0]  sec_bus,
    output logic [7:0]  sub_bus,
    output logic        win_set
);

    logic [31:0] busnr_q;

    // Bus number register: cleared by reset, loaded by a write to its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busnr_q <= 32'd0;
        end else if (wr_en && (reg_idx == REG_BUSNR)) begin
            busnr_q <= wdata;
        end
    end

    assign sec_bus = busnr_q[15:8];
    assign sub_bus = busnr_q[23:16];
    assign win_set = window_set(busnr_q[15:8], busnr_q[23:16]);

    // Read mux over the implemented registers; others read zero.
    always_comb begin
        unique case (reg_idx)
            REG_IDENT: rdata = {DEV_ID, VEN_ID};
            REG_HDR:   rdata = {8'd0, MULTI_FN, HDR_TYPE_BRIDGE, 16'd0};
            REG_BUSNR: rdata = busnr_q;
            REG_SLOT:  rdata = {24'd0, SLOT_NUM};
            default:   rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/cfg_window_match.sv
// Finds the lowest-index downstream port whose programmed bus window
// contains the requested bus. Assumes windows may overlap.
module cfg_window_match #(
    parameter int N_DN  = 3,
    parameter int IDX_W = 2
) (
    input  logic [N_DN-1:0][7:0] sec_bus,
    input  logic [N_DN-1:0][7:0] sub_bus,
    input  logic [N_DN-1:0]      win_set,
    input  logic [7:0]           bus,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);

    logic [N_DN-1:0] in_win;

    for (genvar g = 0; g < N_DN; g++) begin : g_cmp
        assign in_win[g] = win_set[g] && (bus >= sec_bus[g]) && (bus <= sub_bus[g]);
    end

    // Priority encode: scanning downwards leaves the lowest index in place.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N_DN - 1; i >= 0; i--) begin
            if (in_win[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cfg_route_switch.sv
// Configuration request router for a switch with one upstream bridge and
// N_DN downstream bridges. Decides own / internal / forward / unclaimed
// and returns a registered response one cycle after each request.
// Assumes at most one request per cycle and N_DN <= 32.
module cfg_route_switch
    import cfg_route_pkg::*;
#(
    parameter int          N_DN         = 3,
    parameter logic [15:0] VENDOR_ID    = 16'h1A2B,
    parameter logic [15:0] UP_DEVICE_ID = 16'h0C01,
    parameter logic [15:0] DN_DEVICE_ID = 16'h0C02,
    parameter bit          HOTPLUG      = 1'b1,
    parameter int          PORT_W       = (N_DN > 1) ? $clog2(N_DN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_fwd,
    input  logic              req_write,
    input  logic [7:0]        req_bus,
    input  logic [7:0]        req_devfn,
    input  logic [5:0]        req_reg,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_claimed,
    output logic [1:0]        rsp_kind,
    output logic [PORT_W-1:0] rsp_port,
    output logic [31:0]       rsp_rdata
);

    localparam bit DN_MULTI = (N_DN > 1);

    // Upstream port state.
    logic [31:0] up_rdata;
    logic [7:0]  up_sec, up_sub;
    logic        up_set;
    logic        up_wr;

    // Downstream port state.
    logic [N_DN-1:0][31:0] dn_rdata;
    logic [N_DN-1:0][7:0]  dn_sec, dn_sub;
    logic [N_DN-1:0]       dn_set;
    logic [N_DN-1:0]       dn_wr;

    // Routing decode.
    logic              in_up, on_internal, devfn_ok;
    logic              fwd_hit;
    logic [PORT_W-1:0] fwd_idx;
    logic [31:0]       sel_rdata;
    logic              nx_claimed;
    route_kind_e       nx_kind;
    logic [PORT_W-1:0] nx_port;
    logic [31:0]       nx_rdata;

    assign up_wr = req_valid && req_write && !req_fwd;

    cfg_port_regs #(
        .VEN_ID   (VENDOR_ID),
        .DEV_ID   (UP_DEVICE_ID),
        .MULTI_FN (1'b0),
        .SLOT_NUM (8'd0)
    ) u_up_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (up_wr),
        .reg_idx (req_reg),
        .wdata   (req_wdata),
        .rdata   (up_rdata),
        .sec_bus (up_sec),
        .sub_bus (up_sub),
        .win_set (up_set)
    );

    for (genvar g = 0; g < N_DN; g++) begin : g_dn
        localparam logic [7:0] SLOT_G = HOTPLUG ? 8'(g + 1) : 8'd0;

        assign dn_wr[g] = req_valid && req_write && req_fwd && on_internal
                          && (req_devfn == 8'(g));

        cfg_port_regs #(
            .VEN_ID   (VENDOR_ID),
            .DEV_ID   (DN_DEVICE_ID),
            .MULTI_FN (DN_MULTI),
            .SLOT_NUM (SLOT_G)
        ) u_dn_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (dn_wr[g]),
            .reg_idx (req_reg),
            .wdata   (req_wdata),
            .rdata   (dn_rdata[g]),
            .sec_bus (dn_sec[g]),
            .sub_bus (dn_sub[g]),
            .win_set (dn_set[g])
        );
    end

    cfg_window_match #(
        .N_DN  (N_DN),
        .IDX_W (PORT_W)
    ) u_match (
        .sec_bus (dn_sec),
        .sub_bus (dn_sub),
        .win_set (dn_set),
        .bus     (req_bus),
        .hit     (fwd_hit),
        .idx     (fwd_idx)
    );

    assign in_up       = up_set && (req_bus >= up_sec) && (req_bus <= up_sub);
    assign on_internal = in_up && (req_bus == up_sec);
    assign devfn_ok    = (32'(req_devfn) < N_DN);

    // Select the addressed downstream register file by device/function.
    always_comb begin
        sel_rdata = 32'd0;
        for (int i = 0; i < N_DN; i++) begin
            if (req_devfn == 8'(i)) sel_rdata = dn_rdata[i];
        end
    end

    // Routing decision for the current request.
    always_comb begin
        nx_claimed = 1'b0;
        nx_kind    = KIND_NONE;
        nx_port    = '0;
        nx_rdata   = RDATA_UNCLAIMED;
        if (!req_fwd) begin
            nx_claimed = 1'b1;
            nx_kind    = KIND_OWN;
            nx_rdata   = up_rdata;
        end else if (on_internal) begin
            if (devfn_ok) begin
                nx_claimed = 1'b1;
                nx_kind    = KIND_INTERNAL;
                nx_port    = req_devfn[PORT_W-1:0];
                nx_rdata   = sel_rdata;
            end
        end else if (in_up && fwd_hit) begin
            nx_claimed = 1'b1;
            nx_kind    = KIND_FORWARD;
            nx_port    = fwd_idx;
            nx_rdata   = 32'd0;
        end
    end

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_claimed <= 1'b0;
            rsp_kind    <= KIND_NONE;
            rsp_port    <= '0;
            rsp_rdata   <= RDATA_UNCLAIMED;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_claimed <= nx_claimed;
                rsp_kind    <= nx_kind;
                rsp_port    <= nx_port;
                rsp_rdata   <= nx_rdata;
            end
        end
    end

endmodule

// File: rtl/cfg_route_switch_checker.sv
// Protocol checks on the router's ports and upstream window, bound to the top.
module cfg_route_switch_checker
    import cfg_route_pkg::*;
#(
    parameter int N_DN   = 3,
    parameter int PORT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_fwd,
    input logic [7:0]        req_bus,
    input logic [7:0]        req_devfn,
    input logic              rsp_valid,
    input logic              rsp_claimed,
    input logic [1:0]        rsp_kind,
    input logic [PORT_W-1:0] rsp_port,
    input logic [31:0]       rsp_rdata,
    input logic [7:0]        up_sec,
    input logic [7:0]        up_sub
);

    assert_resp_due_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_unclaimed_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_claimed) |-> (rsp_rdata == 32'hFFFF_FFFF && rsp_kind == 2'd0));

    assert_own_claimed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_fwd) |=> (rsp_claimed && rsp_kind == 2'd1));

    assert_unprog_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fwd && up_sec == 8'd0 && up_sub == 8'd0) |=> !rsp_claimed);

    assert_outside_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fwd && (req_bus < up_sec || req_bus > up_sub)) |=> !rsp_claimed);

    assert_missing_fn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fwd && req_bus == up_sec && 32'(req_devfn) >= N_DN) |=> !rsp_claimed);

    assert_port_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'd2) |-> (32'(rsp_port) < N_DN));

endmodule

bind cfg_route_switch cfg_route_switch_checker #(
    .N_DN   (N_DN),
    .PORT_W (PORT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_fwd     (req_fwd),
    .req_bus     (req_bus),
    .req_devfn   (req_devfn),
    .rsp_valid   (rsp_valid),
    .rsp_claimed (rsp_claimed),
    .rsp_kind    (rsp_kind),
    .rsp_port    (rsp_port),
    .rsp_rdata   (rsp_rdata),
    .up_sec      (up_sec),
    .up_sub      (up_sub)
);

// File: tb/cfg_route_switch_bench.sv
// Bench for cfg_route_switch: directed corners plus seeded random traffic
// checked against a model of the bus number registers and routing rules.
module cfg_route_switch_bench;

    localparam int          N      = 3;
    localparam int          PW     = (N > 1) ? $clog2(N) : 1;
    localparam logic [15:0] VEN    = 16'h1A2B;
    localparam logic [15:0] UPDEV  = 16'h0C01;
    localparam logic [15:0] DNDEV  = 16'h0C02;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_fwd = 1'b0;
    logic          req_write = 1'b0;
    logic [7:0]    req_bus = '0;
    logic [7:0]    req_devfn = '0;
    logic [5:0]    req_reg = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid, rsp_claimed;
    logic [1:0]    rsp_kind;
    logic [PW-1:0] rsp_port;
    logic [31:0]   rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Model: index N is the upstream port.
    logic [31:0] m_bus [0:N];

    always #10 clk = ~clk;

    cfg_route_switch #(.N_DN(N), .VENDOR_ID(VEN), .UP_DEVICE_ID(UPDEV),
                       .DN_DEVICE_ID(DNDEV), .HOTPLUG(1'b1)) u_cfg_route_switch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fwd(req_fwd),
        .req_write(req_write), .req_bus(req_bus), .req_devfn(req_devfn),
        .req_reg(req_reg), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_claimed(rsp_claimed), .rsp_kind(rsp_kind), .rsp_port(rsp_port),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input int p, input logic [5:0] r);
        bit up = (p == N);
        case (r)
            6'd0:  return up ? {UPDEV, VEN} : {DNDEV, VEN};
            6'd3:  return {8'd0, (!up && N > 1), 7'h01, 16'd0};
            6'd6:  return m_bus[p];
            6'd16: return up ? 32'd0 : 32'(p + 1);
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit m_set(input int p);
        return (m_bus[p][15:8] != 8'd0) || (m_bus[p][23:16] != 8'd0);
    endfunction

    task automatic do_req(input bit fwd, input bit wr, input logic [7:0] bus,
                          input logic [7:0] devfn, input logic [5:0] rg,
                          input logic [31:0] wd, input string tag);
        bit e_cl = 1'b0;
        logic [1:0] e_kind = 2'd0;
        int e_port = 0;
        logic [31:0] e_rd = 32'hFFFF_FFFF;
        logic [7:0] us = m_bus[N][15:8];
        logic [7:0] ub = m_bus[N][23:16];
        if (!fwd) begin
            e_cl = 1'b1; e_kind = 2'd1; e_rd = m_read(N, rg);
            if (wr && rg == 6'd6) m_bus[N] = wd;
        end else if (m_set(N) && bus >= us && bus <= ub) begin
            if (bus == us) begin
                if (int'(devfn) < N) begin
                    e_cl = 1'b1; e_kind = 2'd2; e_port = int'(devfn);
                    e_rd = m_read(int'(devfn), rg);
                    if (wr && rg == 6'd6) m_bus[int'(devfn)] = wd;
                end
            end else begin
                for (int i = N - 1; i >= 0; i--) begin
                    if (m_set(i) && bus >= m_bus[i][15:8] && bus <= m_bus[i][23:16]) begin
                        e_cl = 1'b1; e_kind = 2'd3; e_port = i; e_rd = 32'd0;
                    end
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_fwd = fwd; req_write = wr; req_bus = bus;
        req_devfn = devfn; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, "valid", 32'(rsp_valid), 32'd1);
        chk(tag, "claimed", 32'(rsp_claimed), 32'(e_cl));
        chk(tag, "kind", 32'(rsp_kind), 32'(e_kind));
        chk(tag, "port", 32'(rsp_port), 32'(e_port));
        chk(tag, "rdata", rsp_rdata, e_rd);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p <= N; p++) m_bus[p] = 32'd0;
        chk("R1", "valid after reset", 32'(rsp_valid), 32'd0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog: got hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int p = 0; p <= N; p++) m_bus[p] = 32'd0;
        do_reset();
        // R1 / R2 / R3 / R4 / R10: own register file after reset
        do_req(0, 0, 8'd0, 8'd0, 6'd6, 32'd0, "R1 own busnr cleared");
        do_req(0, 0, 8'd0, 8'd0, 6'd0, 32'd0, "R3 own ident");
        do_req(0, 0, 8'd0, 8'd0, 6'd3, 32'd0, "R4 own header no mf");
        do_req(0, 0, 8'd0, 8'd0, 6'd16, 32'd0, "R10 own slot zero");
        // R6: upstream window unprogrammed
        do_req(1, 0, 8'd0, 8'd0, 6'd0, 32'd0, "R6 unprog bus0");
        do_req(1, 0, 8'd1, 8'd0, 6'd0, 32'd0, "R6 unprog bus1");
        do_req(1, 1, 8'd0, 8'd0, 6'd6, 32'h0005_0100, "R6 unprog write");
        // R5: program upstream window sec=1 sub=10, byte 3 stored
        do_req(0, 1, 8'd0, 8'd0, 6'd6, 32'hAA0A_0100, "R5 own write busnr");
        do_req(0, 0, 8'd0, 8'd0, 6'd6, 32'd0, "R5 own read busnr");
        do_req(0, 1, 8'd0, 8'd0, 6'd1, 32'h1234_5678, "R5 other index write");
        do_req(0, 0, 8'd0, 8'd0, 6'd1, 32'd0, "R5 other index ignored");
        // R8: internal bus register files
        do_req(1, 0, 8'd1, 8'd0, 6'd0, 32'd0, "R8 R3 port0 ident");
        do_req(1, 0, 8'd1, 8'd2, 6'd3, 32'd0, "R8 R4 port2 header mf");
        do_req(1, 0, 8'd1, 8'd1, 6'd16, 32'd0, "R8 R10 port1 slot");
        do_req(1, 0, 8'd1, 8'd5, 6'd0, 32'd0, "R8 missing function");
        do_req(1, 0, 8'd1, 8'd3, 6'd0, 32'd0, "R8 first missing index");
        // R7: outside upstream window
        do_req(1, 0, 8'd11, 8'd0, 6'd0, 32'd0, "R7 above subordinate");
        do_req(1, 0, 8'd0, 8'd0, 6'd0, 32'd0, "R7 below secondary");
        // R9: no downstream window programmed
        do_req(1, 0, 8'd5, 8'd0, 6'd0, 32'd0, "R9 no port window");
        // R9: overlapping windows, lowest index wins
        do_req(1, 1, 8'd1, 8'd1, 6'd6, 32'h0006_0401, "R9 program port1");
        do_req(1, 1, 8'd1, 8'd2, 6'd6, 32'h0009_0501, "R9 program port2");
        do_req(1, 0, 8'd1, 8'd1, 6'd6, 32'd0, "R5 R8 port1 busnr readback");
        do_req(1, 0, 8'd5, 8'd0, 6'd0, 32'd0, "R9 priority overlap");
        do_req(1, 0, 8'd8, 8'd0, 6'd0, 32'd0, "R9 port2 only");
        do_req(1, 0, 8'd3, 8'd0, 6'd0, 32'd0, "R9 gap unclaimed");
        do_req(1, 1, 8'd1, 8'd0, 6'd6, 32'h0003_0201, "R9 program port0");
        do_req(1, 0, 8'd2, 8'd0, 6'd0, 32'd0, "R9 port0 hit");
        do_req(1, 0, 8'd10, 8'd0, 6'd0, 32'd0, "R9 upper edge no port");
        // R11: idle cycle gives no response
        @(negedge clk);
        chk("R11", "idle no response", 32'(rsp_valid), 32'd0);
        // Random traffic against the model
        for (int k = 0; k < 400; k++) begin
            bit fwd = ($urandom_range(0, 4) != 0);
            bit wr  = ($urandom_range(0, 3) == 0);
            logic [7:0] bus = 8'($urandom_range(0, 12));
            logic [7:0] dfn = 8'($urandom_range(0, 4));
            int pick = $urandom_range(0, 4);
            logic [5:0] rg = (pick == 0) ? 6'd0 : (pick == 1) ? 6'd3 :
                             (pick == 2) ? 6'd16 : (pick == 3) ? 6'd2 : 6'd6;
            logic [31:0] wd = {8'($urandom), 8'($urandom_range(0, 12)),
                               8'($urandom_range(0, 6)), 8'($urandom)};
            if (fwd && wr && $urandom_range(0, 1) == 0) bus = m_bus[N][15:8];
            if (k == 200) do_reset();
            do_req(fwd, wr, bus, dfn, rg, wd, "R2 R8 R9 R11 random");
        end
        // R1: reset makes windows unprogrammed again
        do_reset();
        do_req(1, 0, 8'd5, 8'd0, 6'd0, 32'd0, "R1 R6 after reset");
        do_req(0, 0, 8'd0, 8'd0, 6'd6, 32'd0, "R1 own busnr after reset");
        done = 1'b1;
        summary();
        $finish;
    end

endmodule